// File: doc/BRIEF.md
# Addressed Serial Synthesizer Programming Interface

This block receives configuration words for a dual-loop frequency synthesizer controller over a three-wire serial link made up of a serial clock, a data line and an enable strobe. While the enable is low, each rising serial-clock edge shifts in one bit. A complete word is 19 bits: a 16-bit data field followed by a 3-bit address. When the enable returns high, the address is decoded and the data field goes to one of four holding latches. These latches are the RF main divider ratio, the reference divider ratio, the IF main divider ratio and the control word. Each divider coefficient is sent least significant bit first, inside a word that is otherwise sent most significant bit first. The block therefore reverses the bit order of each coefficient field as it stores it.

All three serial lines are brought into the system clock domain through two-flop synchronisers. A decoded word does not go straight into a latch. It waits in a pending register until the dividers' reload strobe is inactive, so that a ratio never changes in a cycle where a divider is taking its value. After reset every latch reads zero. This includes the test field of the control word, which must stay zero in normal operation. A one-cycle flag reports any write that puts a nonzero test pattern into it.

Top module: `synth_prog_if`

## Requirements
- R1: While reset is asserted, and after reset until the first accepted load, every ratio and control output is zero and `tst_flag` is low.
- R2: A word is accepted only when exactly 19 rising `ser_clk` edges occur while `ser_en` is low. The first bit becomes data bit 15 and the last bit becomes address bit 0. The word takes effect after `ser_en` rises.
- R3: Address 000 writes `rf_ratio`, with `rf_ratio[i]` = data bit (15-i). The first serial bit is therefore the ratio LSB.
- R4: Address 001 writes `ref_ratio`, with `ref_ratio[i]` = data bit (9-i). Data bits 15..10 are ignored.
- R5: Address 010 writes `if_ratio`, with `if_ratio[i]` = data bit (13-i). Data bits 15 and 14 are ignored.
- R6: Address 011 writes the control word. Its fields are taken from the data bits as follows: `tst_bits` = bits 15..12, `cp_hi` = bit 11, `sd_mode` = bit 10, `xo_en` = bit 9, `route_sel` = bit 4 and `cmp_m1` = bits 3..0, where the comparison ratio is `cmp_m1`+1. Bits 8..5 are ignored.
- R7: One accepted word changes at most one latch. Words sent to addresses 100 through 111 change no output.
- R8: A frame with other than 19 clock edges is discarded. Serial clock edges while `ser_en` is high do not count toward the next frame.
- R9: No latch output changes in a cycle that follows a cycle with `reload_busy` high. A word held back by `reload_busy` is applied within a few cycles after `reload_busy` falls.
- R10: `tst_flag` pulses high for exactly one cycle when a control word with a nonzero test field is applied. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_en | input | 1 | Frame enable, low while shifting, asynchronous |
| reload_busy | input | 1 | High while a divider reads its ratio |
| rf_ratio | output | 16 | RF main divider ratio |
| ref_ratio | output | 10 | Reference divider ratio |
| if_ratio | output | 14 | IF main divider ratio |
| tst_bits | output | 4 | Test field of the control word |
| cp_hi | output | 1 | Charge-pump current select |
| sd_mode | output | 1 | S/D mode bit |
| xo_en | output | 1 | Crystal oscillator amplifier enable |
| route_sel | output | 1 | 1: subdivider output to RF loop, common divider output to IF loop |
| cmp_m1 | output | 4 | IF/RF comparison ratio minus one |
| tst_flag | output | 1 | One-cycle pulse on a nonzero test write |

## Verification
The assertions check four properties on every cycle. No latch is ever updated just after a cycle with `reload_busy` high. At most one latch changes per cycle. `tst_flag` never lasts more than one cycle and never appears without a nonzero test field. The outputs are all zero during reset. The bench scenarios cover what only a model of the word can show. These are the bit-reversed mapping of every coefficient field under walking-one and arithmetic patterns at all eight addresses, the rejection of short, long and polluted frames, and the release of a deferred load once the strobe clears.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 3;
  localparam int FRAME_W = DATA_W + ADDR_W;

  // address decode; these values are what the sender encodes
  localparam logic [ADDR_W-1:0] ADR_RF   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_REF  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_IF   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd3;

  // control word field positions inside the data field
  localparam int TST_LSB   = 12;
  localparam int TST_W     = 4;
  localparam int CP_BIT    = 11;
  localparam int SD_BIT    = 10;
  localparam int XO_BIT    = 9;
  localparam int ROUTE_BIT = 4;
  localparam int CMP_LSB   = 0;
  localparam int CMP_W     = 4;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] addr;
  } frame_t;

endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/sp_shift.sv
module sp_shift
  import synth_prog_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk,
  input  logic   sdat,
  input  logic   sen,
  output logic   frm_vld,
  output frame_t frm
);

  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic               sclk_d, sen_d;
  logic [FRAME_W-1:0] sr, sr_n;
  logic [CNT_W-1:0]   cnt, cnt_n;
  logic               vld_n;
  frame_t             frm_n;
  logic               sclk_rise, en_rise;

  assign sclk_rise = sclk & ~sclk_d;
  assign en_rise   = sen & ~sen_d;

  always_comb begin
    sr_n  = sr;
    cnt_n = cnt;
    vld_n = 1'b0;
    frm_n = frm;
    if (en_rise) begin
      vld_n = (cnt == CNT_FULL);
      frm_n = frame_t'(sr);
      cnt_n = '0;
    end else if (sclk_rise && !sen) begin
      sr_n = {sr[FRAME_W-2:0], sdat};
      if (cnt != CNT_SAT) cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      sen_d   <= 1'b0;
      sr      <= '0;
      cnt     <= '0;
      frm_vld <= 1'b0;
      frm     <= '0;
    end else begin
      sclk_d  <= sclk;
      sen_d   <= sen;
      sr      <= sr_n;
      cnt     <= cnt_n;
      frm_vld <= vld_n;
      frm     <= frm_n;
    end
  end

endmodule

// File: rtl/sp_hold.sv
module sp_hold
  import synth_prog_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   frm_vld,
  input  frame_t frm,
  input  logic   reload_busy,
  output logic   ld_go,
  output frame_t ld_frm
);

  logic   pend, pend_n;
  frame_t buf_n;

  assign ld_go = pend & ~reload_busy;

  always_comb begin
    pend_n = pend;
    buf_n  = ld_frm;
    if (ld_go) pend_n = 1'b0;
    if (frm_vld) begin
      pend_n = 1'b1;
      buf_n  = frm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      ld_frm <= '0;
    end else begin
      pend   <= pend_n;
      ld_frm <= buf_n;
    end
  end

endmodule

// File: rtl/sp_bank.sv
module sp_bank
  import synth_prog_pkg::*;
#(
  parameter int RF_W  = 16,
  parameter int REF_W = 10,
  parameter int IF_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_go,
  input  frame_t           ld_frm,
  output logic [RF_W-1:0]  rf_ratio,
  output logic [REF_W-1:0] ref_ratio,
  output logic [IF_W-1:0]  if_ratio,
  output logic [TST_W-1:0] tst_bits,
  output logic             cp_hi,
  output logic             sd_mode,
  output logic             xo_en,
  output logic             route_sel,
  output logic [CMP_W-1:0] cmp_m1,
  output logic             tst_flag
);

  logic [DATA_W-1:0] d;
  logic [RF_W-1:0]   rf_rev;
  logic [REF_W-1:0]  ref_rev;
  logic [IF_W-1:0]   if_rev;

  assign d = ld_frm.data;

  // coefficient fields arrive LSB first: reverse each into normal order
  for (genvar i = 0; i < RF_W; i++) begin : g_rf
    assign rf_rev[i] = d[RF_W-1-i];
  end
  for (genvar i = 0; i < REF_W; i++) begin : g_ref
    assign ref_rev[i] = d[REF_W-1-i];
  end
  for (genvar i = 0; i < IF_W; i++) begin : g_if
    assign if_rev[i] = d[IF_W-1-i];
  end

  logic [RF_W-1:0]  rf_n;
  logic [REF_W-1:0] ref_n;
  logic [IF_W-1:0]  if_n;
  logic [TST_W-1:0] tst_n;
  logic             cp_n, sd_n, xo_n, route_n, flag_n;
  logic [CMP_W-1:0] cmp_n;

  always_comb begin
    rf_n    = rf_ratio;
    ref_n   = ref_ratio;
    if_n    = if_ratio;
    tst_n   = tst_bits;
    cp_n    = cp_hi;
    sd_n    = sd_mode;
    xo_n    = xo_en;
    route_n = route_sel;
    cmp_n   = cmp_m1;
    flag_n  = 1'b0;
    if (ld_go) begin
      case (ld_frm.addr)
        ADR_RF:   rf_n  = rf_rev;
        ADR_REF:  ref_n = ref_rev;
        ADR_IF:   if_n  = if_rev;
        ADR_CTRL: begin
          tst_n   = d[TST_LSB +: TST_W];
          cp_n    = d[CP_BIT];
          sd_n    = d[SD_BIT];
          xo_n    = d[XO_BIT];
          route_n = d[ROUTE_BIT];
          cmp_n   = d[CMP_LSB +: CMP_W];
          flag_n  = |d[TST_LSB +: TST_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_ratio  <= '0;
      ref_ratio <= '0;
      if_ratio  <= '0;
      tst_bits  <= '0;
      cp_hi     <= 1'b0;
      sd_mode   <= 1'b0;
      xo_en     <= 1'b0;
      route_sel <= 1'b0;
      cmp_m1    <= '0;
      tst_flag  <= 1'b0;
    end else begin
      rf_ratio  <= rf_n;
      ref_ratio <= ref_n;
      if_ratio  <= if_n;
      tst_bits  <= tst_n;
      cp_hi     <= cp_n;
      sd_mode   <= sd_n;
      xo_en     <= xo_n;
      route_sel <= route_n;
      cmp_m1    <= cmp_n;
      tst_flag  <= flag_n;
    end
  end

endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int RF_W  = 16,
  parameter int REF_W = 10,
  parameter int IF_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_en,
  input  logic             reload_busy,
  output logic [RF_W-1:0]  rf_ratio,
  output logic [REF_W-1:0] ref_ratio,
  output logic [IF_W-1:0]  if_ratio,
  output logic [3:0]       tst_bits,
  output logic             cp_hi,
  output logic             sd_mode,
  output logic             xo_en,
  output logic             route_sel,
  output logic [3:0]       cmp_m1,
  output logic             tst_flag
);

  // reset asserted asynchronously, released on a clock edge
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic [2:0] ser_s;
  logic       frm_vld, ld_go;
  frame_t     frm, ld_frm;

  sp_sync #(.WIDTH(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_s),
    .d    ({ser_en, ser_dat, ser_clk}),
    .q    (ser_s)
  );

  sp_shift u_shift (
    .clk    (clk),
    .rst_n  (rst_s),
    .sclk   (ser_s[0]),
    .sdat   (ser_s[1]),
    .sen    (ser_s[2]),
    .frm_vld(frm_vld),
    .frm    (frm)
  );

  sp_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_s),
    .frm_vld    (frm_vld),
    .frm        (frm),
    .reload_busy(reload_busy),
    .ld_go      (ld_go),
    .ld_frm     (ld_frm)
  );

  sp_bank #(.RF_W(RF_W), .REF_W(REF_W), .IF_W(IF_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_s),
    .ld_go    (ld_go),
    .ld_frm   (ld_frm),
    .rf_ratio (rf_ratio),
    .ref_ratio(ref_ratio),
    .if_ratio (if_ratio),
    .tst_bits (tst_bits),
    .cp_hi    (cp_hi),
    .sd_mode  (sd_mode),
    .xo_en    (xo_en),
    .route_sel(route_sel),
    .cmp_m1   (cmp_m1),
    .tst_flag (tst_flag)
  );

endmodule

// File: rtl/sp_chk.sv
module sp_chk #(
  parameter int RF_W  = 16,
  parameter int REF_W = 10,
  parameter int IF_W  = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reload_busy,
  input logic [RF_W-1:0]  rf_ratio,
  input logic [REF_W-1:0] ref_ratio,
  input logic [IF_W-1:0]  if_ratio,
  input logic [3:0]       tst_bits,
  input logic             cp_hi,
  input logic             sd_mode,
  input logic             xo_en,
  input logic             route_sel,
  input logic [3:0]       cmp_m1,
  input logic             tst_flag
);

  logic [12:0] ctrl_w;
  assign ctrl_w = {tst_bits, cp_hi, sd_mode, xo_en, route_sel, cmp_m1, tst_flag};

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_zero_chk: assert (rf_ratio == '0 && ref_ratio == '0 && if_ratio == '0 && ctrl_w == '0);
    end
  end

  // R9
  no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({rf_ratio, ref_ratio, if_ratio, tst_bits, cp_hi, sd_mode, xo_en, route_sel, cmp_m1})
      |-> !$past(reload_busy));

  // R7
  one_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!$stable(rf_ratio), !$stable(ref_ratio), !$stable(if_ratio),
                !$stable({tst_bits, cp_hi, sd_mode, xo_en, route_sel, cmp_m1})}) <= 1);

  // R10
  flag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tst_flag |-> (tst_bits != 4'd0));

  // R10
  flag_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tst_flag |=> !tst_flag);

endmodule

bind synth_prog_if sp_chk #(.RF_W(RF_W), .REF_W(REF_W), .IF_W(IF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reload_busy(reload_busy),
  .rf_ratio   (rf_ratio),
  .ref_ratio  (ref_ratio),
  .if_ratio   (if_ratio),
  .tst_bits   (tst_bits),
  .cp_hi      (cp_hi),
  .sd_mode    (sd_mode),
  .xo_en      (xo_en),
  .route_sel  (route_sel),
  .cmp_m1     (cmp_m1),
  .tst_flag   (tst_flag)
);

// File: tb/sim_synth_prog_if.sv
`timescale 1ns/1ps
module sim_synth_prog_if;

  logic        clk = 1'b0;
  logic        rst_n, ser_clk, ser_dat, ser_en, reload_busy;
  logic [15:0] rf_ratio;
  logic [9:0]  ref_ratio;
  logic [13:0] if_ratio;
  logic [3:0]  tst_bits, cmp_m1;
  logic        cp_hi, sd_mode, xo_en, route_sel, tst_flag;

  always #2 clk = ~clk;

  synth_prog_if u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
    .reload_busy(reload_busy), .rf_ratio(rf_ratio), .ref_ratio(ref_ratio),
    .if_ratio(if_ratio), .tst_bits(tst_bits), .cp_hi(cp_hi), .sd_mode(sd_mode),
    .xo_en(xo_en), .route_sel(route_sel), .cmp_m1(cmp_m1), .tst_flag(tst_flag)
  );

  int n_vec = 0, n_bad = 0, flag_seen = 0, flag_exp = 0;
  bit done = 0;

  logic [15:0] e_rf;
  logic [9:0]  e_ref;
  logic [13:0] e_if;
  logic [3:0]  e_tst, e_cmp;
  logic        e_cp, e_sd, e_xo, e_route;

  always @(posedge clk) if (rst_n && tst_flag) flag_seen++;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag == "" ? "R3" : tag, "rf_ratio", 32'(rf_ratio), 32'(e_rf));
    chk(tag == "" ? "R4" : tag, "ref_ratio", 32'(ref_ratio), 32'(e_ref));
    chk(tag == "" ? "R5" : tag, "if_ratio", 32'(if_ratio), 32'(e_if));
    chk(tag == "" ? "R6" : tag, "ctrl",
        32'({tst_bits, cp_hi, sd_mode, xo_en, route_sel, cmp_m1}),
        32'({e_tst, e_cp, e_sd, e_xo, e_route, e_cmp}));
    chk("R10", "flag pulses", 32'(flag_seen), 32'(flag_exp));
  endtask

  task automatic shift_frame(input logic [18:0] w, input int nbits);
    ser_en = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i < 19) ser_dat = w[18-i];
      else        ser_dat = 1'b0;
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (3) @(negedge clk);
    ser_en = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic model(input logic [15:0] d, input logic [2:0] a);
    case (a)
      3'd0: for (int i = 0; i < 16; i++) e_rf[i]  = d[15-i];
      3'd1: for (int i = 0; i < 10; i++) e_ref[i] = d[9-i];
      3'd2: for (int i = 0; i < 14; i++) e_if[i]  = d[13-i];
      3'd3: begin
        e_tst = d[15:12]; e_cp = d[11]; e_sd = d[10]; e_xo = d[9];
        e_route = d[4]; e_cmp = d[3:0];
        if (d[15:12] != 4'd0) flag_exp++;
      end
      default: ;
    endcase
  endtask

  task automatic apply(input logic [15:0] d, input logic [2:0] a);
    shift_frame({d, a}, 19);
    model(d, a);
    check_all(a >= 3'd4 ? "R7" : "");
  endtask

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; ser_en = 1'b1; reload_busy = 1'b0;
    e_rf = '0; e_ref = '0; e_if = '0; e_tst = '0; e_cmp = '0;
    e_cp = 0; e_sd = 0; e_xo = 0; e_route = 0;
    repeat (5) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_all("R1");

    // R2: the first serial bit lands in the ratio LSB
    shift_frame({16'h8000, 3'd0}, 19);
    model(16'h8000, 3'd0);
    chk("R2", "first bit is LSB", 32'(rf_ratio), 32'h1);

    // sweep every address with walking ones and arithmetic patterns
    for (int a = 0; a < 8; a++) begin
      for (int k = 0; k < 16; k++) apply(16'h1 << k, 3'(a));
      for (int k = 0; k < 8; k++)
        apply(16'((a * 16'h1357 + k * 16'h9e37) ^ (16'hffff >> k)), 3'(a));
      apply(16'hffff, 3'(a));
      apply(16'h0000, 3'(a));
    end

    // leave distinctive values in place
    apply(16'hc35a, 3'd0);
    apply(16'h5e7b, 3'd3);

    // R8: short and long frames discarded
    shift_frame({16'ha5a5, 3'd0}, 18);
    check_all("R8");
    shift_frame({16'h0ff0, 3'd1}, 20);
    check_all("R8");

    // R8: clock edges while enable is high must not spoil the next frame
    for (int i = 0; i < 5; i++) begin
      ser_dat = i[0];
      repeat (3) @(negedge clk); ser_clk = 1'b1;
      repeat (3) @(negedge clk); ser_clk = 1'b0;
    end
    shift_frame({16'h3c96, 3'd2}, 19);
    model(16'h3c96, 3'd2);
    check_all("R8");

    // R9: load held while reload strobe is active
    reload_busy = 1'b1;
    shift_frame({16'h1248, 3'd0}, 19);
    repeat (20) @(negedge clk);
    chk("R9", "held while busy", 32'(rf_ratio), 32'(e_rf));
    reload_busy = 1'b0;
    repeat (4) @(negedge clk);
    model(16'h1248, 3'd0);
    chk("R9", "applied after release", 32'(rf_ratio), 32'(e_rf));
    check_all("R9");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule